// File: doc/BRIEF.md
# Dual-Clock Prefetch FIFO

This block passes words from one clock domain to another through a small storage array and a prefetch output register. Reads use the fall-through style: the oldest word is always presented on `rdData` while `outReadyN` is low, and no request is needed to bring it there. A read enable taken while a word is presented consumes that word, and the next one is loaded in the same read-clock edge when the array has one. Because the output register holds a word of its own, the block stores one word more than its array: 2^ADDR_W + 1 words (17 with the default parameters).

Each side has an active-low ready flag. The write side also gives almost-full and half-full. The read side gives almost-empty. The almost-empty and almost-full thresholds are parameters. Pointers cross between the domains as gray code through two-flop synchronizers. Each side therefore sees the other side's progress a few of its own clock edges late. Each flag errs toward the safe side while that news is in flight.

Top module: `prefetch_fifo`

## Requirements
- R1: While their resets are held low and right after release, `inReadyN`=0, `outReadyN`=1, `almostEmptyN`=0, `almostFullN`=1 and `halfFullN`=1.
- R2: A word written into an empty block appears on `rdData` with `outReadyN` low without any read enable. This happens no earlier than the third and no later than the fifth rising `rdClk` edge counted from the write edge (nominally the third; later when the two edges nearly coincide). The word stays presented until it is read.
- R3: Words leave in the order they were written, under both burst and interleaved traffic. A word is consumed at a rising `rdClk` edge with `rdEnN`=0 and `outReadyN`=0, and `rdData` changes only when a new word is loaded.
- R4: A read enable taken while `outReadyN` is high has no effect: no word is lost and the next word written is the next one presented.
- R5: The block holds 2^ADDR_W + 1 words. `inReadyN` goes high at the write edge that stores the last of them. A write taken while `inReadyN` is high is dropped.
- R6: `almostEmptyN` is high when the read side counts at least AE_OFS+2 stored words, and low otherwise. It rises between the third and fifth `rdClk` edge after the write that reaches that count. It falls at the very `rdClk` edge of the read that takes the count below it.
- R7: `almostFullN` goes low at the write edge that makes the stored count reach 2^ADDR_W + 1 − AF_OFS.
- R8: `halfFullN` goes low at the write edge that makes the stored count exceed half the capacity (rounded down). It returns high once reads bring the count to half or less and that news has crossed to the write side.
- R9: Both enables are active low and are sampled only on rising edges of their own clock.
- R10: After the block has been drained, the write-side flags return within a few write-clock edges to `inReadyN`=0, `almostFullN`=1 and `halfFullN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| wrRstN | input | 1 | Write-side synchronous reset, active low |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | DATA_W | Word to store |
| inReadyN | output | 1 | Low while a write can be taken |
| almostFullN | output | 1 | Low when the count has reached capacity minus AF_OFS |
| halfFullN | output | 1 | Low when more than half the capacity is stored |
| rdClk | input | 1 | Read clock |
| rdRstN | input | 1 | Read-side synchronous reset, active low |
| rdEnN | input | 1 | Read enable, active low |
| rdData | output | DATA_W | Presented (oldest) word |
| outReadyN | output | 1 | Low while `rdData` holds a valid word |
| almostEmptyN | output | 1 | Low when at most AE_OFS+1 words are counted |

## Verification
The assertions check several invariants on every cycle: the array never holds more words than it has slots, a write refused for fullness leaves the write pointer alone, and a read taken while nothing is presented leaves the read pointer alone. They also check that the presented-word flag always matches the gap between the fetch and consume pointers, that the output data holds between loads, and that an empty output forces almost-empty low. Several things only the directed scenarios can show: word order and contents, exact flag thresholds, the flags' latency windows across the two unrelated clocks, the dropped write at capacity, and the recovery of the write flags after a drain.

// File: rtl/pfifo_pkg.sv
`timescale 1ns/1ps
package pfifo_pkg;
  // strobes from control to datapath; wrStb lives in the write domain,
  // fetchStb in the read domain
  typedef struct packed {
    logic wrStb;
    logic fetchStb;
  } pfStrobe_t;
endpackage

// File: rtl/pfifo_ptr_xfer.sv
`timescale 1ns/1ps
module pfifo_ptr_xfer #(
  parameter int PW = 5
) (
  input  logic          srcClk,
  input  logic          srcRstN,
  input  logic [PW-1:0] srcBinNext,
  input  logic          dstClk,
  input  logic          dstRstN,
  output logic [PW-1:0] dstBin
);
  logic [PW-1:0] srcGray;
  logic [PW-1:0] syncA;
  logic [PW-1:0] syncB;

  // gray register in the source domain, loaded from the next pointer value
  always_ff @(posedge srcClk) begin
    if (!srcRstN) srcGray <= '0;
    else          srcGray <= srcBinNext ^ (srcBinNext >> 1);
  end

  always_ff @(posedge dstClk) begin
    if (!dstRstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= srcGray;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_bin
    assign dstBin[i] = ^(syncB >> i);
  end
endmodule

// File: rtl/pfifo_dpath.sv
`timescale 1ns/1ps
module pfifo_dpath
  import pfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rrstN,
  input  pfStrobe_t         stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  // prefetch register: holds the presented word
  always_ff @(posedge rclk) begin
    if (!rrstN)            rdData <= '0;
    else if (stb.fetchStb) rdData <= mem[rdAddr];
  end

  AST_OUT_HOLDS: assert property (@(posedge rclk) disable iff (!rrstN)
    !stb.fetchStb |=> $stable(rdData)) else $error("output changed without a fetch"); // R3
endmodule

// File: rtl/pfifo_ctrl.sv
`timescale 1ns/1ps
module pfifo_ctrl
  import pfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic              wclk,
  input  logic              wrstN,
  input  logic              wenN,
  input  logic              rclk,
  input  logic              rrstN,
  input  logic              renN,
  output pfStrobe_t         stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              inReadyN,
  output logic              afN,
  output logic              hfN,
  output logic              outReadyN,
  output logic              aeN
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CAP   = DEPTH + 1;
  localparam int HALF  = CAP / 2;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrPtr, wrPtrNext, popSyncW, fetchSyncW;
  logic [PW-1:0] wrFill, arrFill, wrOcc;
  logic          wrGo;

  assign wrGo      = !wenN && !inReadyN;
  assign wrPtrNext = wrPtr + PW'(wrGo);
  assign wrFill    = wrPtrNext - popSyncW;
  assign arrFill   = wrPtrNext - fetchSyncW;
  assign wrOcc     = wrPtr - fetchSyncW;

  always_ff @(posedge wclk) begin
    if (!wrstN) begin
      wrPtr    <= '0;
      inReadyN <= 1'b0;
      afN      <= 1'b1;
      hfN      <= 1'b1;
    end else begin
      wrPtr    <= wrPtrNext;
      inReadyN <= (arrFill == PW'(DEPTH));
      afN      <= !(wrFill >= PW'(CAP - AF_OFS));
      hfN      <= !(wrFill > PW'(HALF));
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] fetchPtr, popPtr, wrSyncR, fetchNext, popNext, rdFill;
  logic          outValid, popGo, fetchGo;

  assign popGo     = !renN && outValid;
  assign fetchGo   = (wrSyncR != fetchPtr) && (!outValid || popGo);
  assign fetchNext = fetchPtr + PW'(fetchGo);
  assign popNext   = popPtr + PW'(popGo);
  assign rdFill    = wrSyncR - popNext;

  always_ff @(posedge rclk) begin
    if (!rrstN) begin
      fetchPtr <= '0;
      popPtr   <= '0;
      outValid <= 1'b0;
      aeN      <= 1'b0;
    end else begin
      fetchPtr <= fetchNext;
      popPtr   <= popNext;
      outValid <= fetchGo || (outValid && !popGo);
      aeN      <= (rdFill > PW'(AE_OFS + 1));
    end
  end

  assign outReadyN    = !outValid;
  assign stb.wrStb    = wrGo;
  assign stb.fetchStb = fetchGo;
  assign wrAddr       = wrPtr[ADDR_W-1:0];
  assign rdAddr       = fetchPtr[ADDR_W-1:0];

  // ---------------- pointer crossings ----------------
  pfifo_ptr_xfer #(.PW(PW)) u_wrToRd (
    .srcClk(wclk), .srcRstN(wrstN), .srcBinNext(wrPtrNext),
    .dstClk(rclk), .dstRstN(rrstN), .dstBin(wrSyncR)
  );
  pfifo_ptr_xfer #(.PW(PW)) u_popToWr (
    .srcClk(rclk), .srcRstN(rrstN), .srcBinNext(popNext),
    .dstClk(wclk), .dstRstN(wrstN), .dstBin(popSyncW)
  );
  pfifo_ptr_xfer #(.PW(PW)) u_fetchToWr (
    .srcClk(rclk), .srcRstN(rrstN), .srcBinNext(fetchNext),
    .dstClk(wclk), .dstRstN(wrstN), .dstBin(fetchSyncW)
  );

  // ---------------- assertions ----------------
  AST_ARRAY_BOUND: assert property (@(posedge wclk) disable iff (!wrstN)
    wrOcc <= PW'(DEPTH)) else $error("array over-committed"); // R5
  AST_FULL_DROP: assert property (@(posedge wclk) disable iff (!wrstN)
    (inReadyN && !wenN) |=> $stable(wrPtr)) else $error("write taken while full"); // R5
  AST_EMPTY_READ: assert property (@(posedge rclk) disable iff (!rrstN)
    (outReadyN && !renN) |=> $stable(popPtr)) else $error("read taken while empty"); // R4
  AST_SHOWN_MATCH: assert property (@(posedge rclk) disable iff (!rrstN)
    outReadyN == (fetchPtr == popPtr)) else $error("presented flag out of step"); // R2
  AST_AE_WHEN_DRY: assert property (@(posedge rclk) disable iff (!rrstN)
    outReadyN |-> !aeN) else $error("almost-empty high with nothing shown"); // R6

  if (CAP - AF_OFS > HALF) begin : g_order
    AST_AF_WITHIN_HF: assert property (@(posedge wclk) disable iff (!wrstN)
      !afN |-> !hfN) else $error("almost-full without half-full"); // R8
  end
endmodule

// File: rtl/prefetch_fifo.sv
`timescale 1ns/1ps
module prefetch_fifo
  import pfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic              inReadyN,
  output logic              almostFullN,
  output logic              halfFullN,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              outReadyN,
  output logic              almostEmptyN
);
  pfStrobe_t         stb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  pfifo_ctrl #(.ADDR_W(ADDR_W), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_ctrl (
    .wclk(wrClk), .wrstN(wrRstN), .wenN(wrEnN),
    .rclk(rdClk), .rrstN(rdRstN), .renN(rdEnN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inReadyN(inReadyN), .afN(almostFullN), .hfN(halfFullN),
    .outReadyN(outReadyN), .aeN(almostEmptyN)
  );

  pfifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .wclk(wrClk), .rclk(rdClk), .rrstN(rdRstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/prefetch_fifo_bench.sv
`timescale 1ns/1ps
module prefetch_fifo_bench;
  localparam int DW  = 9;
  localparam int AW  = 4;
  localparam int AE  = 2;
  localparam int AF  = 2;
  localparam int CAP = (1 << AW) + 1;

  logic wclk = 0, rclk = 0;
  logic wrstN = 0, rrstN = 0;
  logic wenN = 1, renN = 1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic inReadyN, afN, hfN, outReadyN, aeN;

  int checks = 0, fails = 0;
  logic [DW-1:0] model[$];

  always #5 wclk = ~wclk;  // 10 ns write clock
  always #7 rclk = ~rclk;  // unrelated read clock

  prefetch_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_OFS(AE), .AF_OFS(AF)) u_prefetch_fifo (
    .wrClk(wclk), .wrRstN(wrstN), .wrEnN(wenN), .wrData(wrData),
    .inReadyN(inReadyN), .almostFullN(afN), .halfFullN(hfN),
    .rdClk(rclk), .rdRstN(rrstN), .rdEnN(renN), .rdData(rdData),
    .outReadyN(outReadyN), .almostEmptyN(aeN)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic writeWord(logic [DW-1:0] v);
    @(negedge wclk);
    if (!inReadyN) model.push_back(v);
    wenN = 0; wrData = v;
    @(negedge wclk);
    wenN = 1;
  endtask

  // write once, then count rdClk edges until the watched flag changes
  task automatic writeWatch(logic [DW-1:0] v, bit watchAe, output int edges);
    @(negedge wclk);
    model.push_back(v);
    wenN = 0; wrData = v;
    @(posedge wclk);
    #1 wenN = 1;
    edges = 0;
    while (edges < 8) begin
      @(posedge rclk);
      edges++;
      #1;
      if (watchAe ? (aeN == 1'b1) : (outReadyN == 1'b0)) break;
    end
  endtask

  task automatic popWord(string tag);
    int waitN = 0;
    @(negedge rclk);
    while (outReadyN && waitN < 20) begin
      @(negedge rclk);
      waitN++;
    end
    check({tag, " ready"}, outReadyN, 0);
    check({tag, " data"}, rdData, model.size() ? model[0] : 0);
    renN = 0;
    @(negedge rclk);
    renN = 1;
    if (model.size()) void'(model.pop_front());
  endtask

  task automatic t_reset();
    repeat (3) @(negedge wclk);
    check("R1 inReadyN in reset", inReadyN, 0);
    wrstN = 1;
    @(negedge rclk);
    rrstN = 1;
    @(negedge wclk);
    check("R1 inReadyN", inReadyN, 0);
    check("R1 outReadyN", outReadyN, 1);
    check("R1 almostEmptyN", aeN, 0);
    check("R1 almostFullN", afN, 1);
    check("R1 halfFullN", hfN, 1);
  endtask

  task automatic t_fallthrough();
    int edges;
    writeWatch(9'h1A5, 1'b0, edges);
    check("R2 latency not before third edge", int'(edges >= 3), 1);
    check("R2 latency by fifth edge", int'(edges <= 5), 1);
    check("R2 data shown", rdData, 9'h1A5);
    repeat (5) @(negedge rclk);
    check("R2 held without read", rdData, 9'h1A5);
    check("R2 still ready", outReadyN, 0);
    popWord("R2 pop");
    settle();
    check("R2 empty after pop", outReadyN, 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 10; i++) writeWord(DW'((i * 37 + 5) & 9'h1FF));
    for (int i = 0; i < 10; i++) popWord("R3 burst");
    fork
      for (int i = 0; i < 12; i++) writeWord(DW'((i * 91 + 3) & 9'h1FF));
      for (int i = 0; i < 12; i++) popWord("R3 R9 interleaved");
    join
    settle();
    check("R3 drained", outReadyN, 1);
  endtask

  task automatic t_emptyRead();
    settle();
    @(negedge rclk);
    renN = 0;
    repeat (4) @(negedge rclk);
    check("R4 nothing shown", outReadyN, 1);
    renN = 1;
    writeWord(9'h0F3);
    popWord("R4 next word");
    settle();
    check("R4 empty again", outReadyN, 1);
  endtask

  task automatic t_fill();
    writeWord(9'h100);
    settle();
    for (int k = 2; k <= CAP; k++) begin
      writeWord(DW'(9'h100 + k));
      check($sformatf("R7 almostFullN k=%0d", k), afN, (k >= CAP - AF) ? 0 : 1);
      check($sformatf("R8 halfFullN k=%0d", k), hfN, (k > CAP / 2) ? 0 : 1);
      check($sformatf("R5 inReadyN k=%0d", k), inReadyN, (k == CAP) ? 1 : 0);
    end
    writeWord(9'h1FF);
    check("R5 stays full", inReadyN, 1);
    check("R5 stored count", model.size(), CAP);
    for (int k = 0; k < CAP; k++) popWord("R5 drain");
    settle();
    check("R5 extra write dropped", outReadyN, 1);
    check("R10 inReadyN", inReadyN, 0);
    check("R10 almostFullN", afN, 1);
    check("R8 R10 halfFullN released", hfN, 1);
  endtask

  task automatic t_almostEmpty();
    int edges;
    for (int k = 1; k <= AE + 1; k++) begin
      writeWord(DW'(9'h040 + k));
      settle();
      check($sformatf("R6 low at %0d", k), aeN, 0);
    end
    writeWatch(9'h055, 1'b1, edges);
    check("R6 rise not before third edge", int'(edges >= 3), 1);
    check("R6 rise by fifth edge", int'(edges <= 5), 1);
    writeWord(9'h056);
    settle();
    check("R6 high above threshold", aeN, 1);
    while (model.size() > 0) begin
      popWord("R6 pop");
      check($sformatf("R6 after pop size=%0d", model.size()), aeN,
            (model.size() >= AE + 2) ? 1 : 0);
    end
  endtask

  initial begin
    t_reset();
    t_fallthrough();
    t_order();
    t_emptyRead();
    t_fill();
    t_almostEmpty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule